// File: doc/BRIEF.md
# Polling Bus Arbiter

This block hands a shared bus to one of several units without any priority encoder. A central controller drives a binary poll number to every unit at once. Each unit compares that number with its own fixed index. When the two match and the unit has something to transfer, it raises its request line in that same cycle. The unit then owns the bus and drives the shared busy line until it reports that it has finished.

While the bus is owned, the poll number stays where it is. Once the owner lets go, the controller moves on to the next number. Units therefore get their turns in a rotating order, and no unit can starve the others. The block contains the poll controller and one comparator-and-ownership slice per unit. It is parameterized by the unit count, and the poll number is as wide as needed to address every unit.

Top module: `poll_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, the poll number reads 0, busy is low and no request line is raised.
- R2: A request bit `req_o[i]` rises only when `want_i[i]` is high, the poll number equals i and busy is low. It also stays low in the single cycle after busy falls, even if the previous owner still wants the bus.
- R3: While busy is low and no request is raised, the poll number steps by one every cycle. After UNITS-1 it returns to 0.
- R4: A raised request makes busy high from the next cycle on.
- R5: The poll number holds its value in the request cycle and in every cycle busy is high.
- R6: In the cycle after busy falls, the poll number shows the owner's index plus one, wrapping modulo UNITS. Units that want the bus continuously are therefore served in ascending index order with wrap-around.
- R7: Once raised, busy stays high until the owning unit pulses its `done_i` bit. That bit is sampled at a clock edge, and busy is low from the following cycle. A `done_i` bit from any other unit, or any `done_i` while the bus is idle, has no effect on busy or on the poll sequence.
- R8: At most one request bit is high in any cycle, and none is high while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| want_i | input | UNITS | Per-unit wish to use the bus |
| done_i | input | UNITS | Per-unit end-of-use pulse, acted on only for the owner |
| poll_cnt_o | output | CNT_W | Broadcast poll number (binary unit index) |
| req_o | output | UNITS | Per-unit request, the claim of the polled unit |
| busy_o | output | 1 | Shared bus-in-use line |

## Verification
Several input patterns exercise the poll sequence:
- With no wants at all, the bench checks the free-running step and the wrap from the top index to 0.
- A single unit that wants the bus long before its number comes up shows that a non-matching want stays silent.
- Done pulses from a non-owner and on an idle bus are applied; they separate the owner's release from ignored inputs.
- Two units that keep their wants high across several grants expose the rotating order, and the silent cycle just after each release.

Every grant is matched against an expected queue that also checks which number was on the poll lines at the time.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

    // Controller phase: stepping through unit numbers, or parked on an owner
    typedef enum logic [0:0] {
        PH_SCAN = 1'b0,
        PH_PARK = 1'b1
    } poll_phase_e;

    // Per-unit registered state
    typedef struct packed {
        logic owns;
    } unit_reg_t;

endpackage

// File: rtl/poll_ctrl.sv
module poll_ctrl
    import poll_arb_pkg::*;
#(
    parameter int UNITS = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_req_i,
    input  logic             busy_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             open_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNITS - 1);

    typedef struct packed {
        poll_phase_e      phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        cnt_next = (r_q.cnt == LAST) ? '0 : r_q.cnt + CNT_W'(1);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_SCAN: begin
                if (any_req_i) begin
                    r_d.phase = PH_PARK;
                end else begin
                    r_d.cnt = cnt_next;
                end
            end
            PH_PARK: begin
                if (!busy_i) begin
                    r_d.phase = PH_SCAN;
                    r_d.cnt   = cnt_next;
                end
            end
            default: r_d.phase = PH_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase <= PH_SCAN;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o  = r_q.cnt;
    assign open_o = (r_q.phase == PH_SCAN) && !busy_i;

    // R5
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_PARK && busy_i) |=> (cnt_o == $past(cnt_o)));

    // R3
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= LAST);

endmodule

// File: rtl/poll_unit.sv
module poll_unit
    import poll_arb_pkg::*;
#(
    parameter int UNITS = 8,
    parameter int CNT_W = 3,
    parameter int ID    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] poll_cnt_i,
    input  logic             open_i,
    output logic             req_o,
    output logic             owns_o
);

    localparam logic [CNT_W-1:0] MY_NUM = CNT_W'(ID);

    unit_reg_t u_d, u_q;
    logic      polled;

    always_comb begin
        polled = (poll_cnt_i == MY_NUM);
        req_o  = want_i && open_i && polled;
        u_d    = u_q;
        if (req_o) begin
            u_d.owns = 1'b1;
        end else if (u_q.owns && done_i) begin
            u_d.owns = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q.owns <= 1'b0;
        end else begin
            u_q <= u_d;
        end
    end

    assign owns_o = u_q.owns;

    // R4
    claim_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> owns_o);

    // R7
    owner_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owns_o && !done_i) |=> owns_o);

    // R7
    owner_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owns_o && done_i) |=> !owns_o);

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
    parameter  int UNITS = 8,
    localparam int CNT_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [UNITS-1:0] want_i,
    input  logic [UNITS-1:0] done_i,
    output logic [CNT_W-1:0] poll_cnt_o,
    output logic [UNITS-1:0] req_o,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNITS - 1);

    logic [UNITS-1:0] owns;
    logic             open;
    logic             any_req;

    assign any_req = |req_o;
    assign busy_o  = |owns;

    poll_ctrl #(
        .UNITS (UNITS),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req_i (any_req),
        .busy_i    (busy_o),
        .cnt_o     (poll_cnt_o),
        .open_o    (open)
    );

    for (genvar gi = 0; gi < UNITS; gi++) begin : g_unit
        poll_unit #(
            .UNITS (UNITS),
            .CNT_W (CNT_W),
            .ID    (gi)
        ) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .want_i     (want_i[gi]),
            .done_i     (done_i[gi]),
            .poll_cnt_i (poll_cnt_o),
            .open_i     (open),
            .req_o      (req_o[gi]),
            .owns_o     (owns[gi])
        );

        // R2
        req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_o[gi] |-> (want_i[gi] && poll_cnt_o == CNT_W'(gi)));
    end

    function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
        return (v == LAST) ? '0 : v + CNT_W'(1);
    endfunction

    // R3
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_o == '0) |=> (poll_cnt_o == step($past(poll_cnt_o))));

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req || busy_o) |=> $stable(poll_cnt_o));

    // R6
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |=> (poll_cnt_o == step($past(poll_cnt_o))));

    // R8
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_o));

    // R8
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (req_o == '0));

    // R4
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> busy_o);

    // R8
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owns));

endmodule

// File: tb/poll_arbiter_tb.sv
module poll_arbiter_tb;

    localparam int UNITS = 8;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [UNITS-1:0] want_i = '0;
    logic [UNITS-1:0] done_i = '0;
    logic [CNT_W-1:0] poll_cnt_o;
    logic [UNITS-1:0] req_o;
    logic             busy_o;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    poll_arbiter #(.UNITS(UNITS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_i     (want_i),
        .done_i     (done_i),
        .poll_cnt_o (poll_cnt_o),
        .req_o      (req_o),
        .busy_o     (busy_o)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_grant(input int u);
        exp_q.push_back(u);
    endtask

    // monitor: every request seen must match the next queued unit and the poll lines
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && req_o != '0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected grant", int'(req_o), 0);
                end else begin
                    automatic int e = exp_q.pop_front();
                    check(req_o == (UNITS'(1) << e), "R6 grant order", int'(req_o), 1 << e);
                    check(int'(poll_cnt_o) == e, "R2 poll number at grant", int'(poll_cnt_o), e);
                end
            end
        end
    end

    task automatic serve(input int u, input int hold);
        bit seen = 1'b0;
        for (int k = 0; k < 24 && !seen; k++) begin
            @(negedge clk);
            #1;
            if (req_o[u]) seen = 1'b1;
        end
        check(seen, "R4 request seen", int'(seen), 1);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            #1;
            check(busy_o && int'(poll_cnt_o) == u, "R5 frozen while busy", int'(poll_cnt_o), u);
        end
        @(negedge clk);
        done_i[u] = 1'b1;
        @(negedge clk);
        done_i[u] = 1'b0;
        #1;
        check(!busy_o, "R7 owner release", int'(busy_o), 0);
        check(req_o == '0, "R2 quiet after release", int'(req_o), 0);
        check(int'(poll_cnt_o) == u, "R5 still parked", int'(poll_cnt_o), u);
        @(negedge clk);
        #1;
        check(int'(poll_cnt_o) == (u + 1) % UNITS, "R6 resume at next", int'(poll_cnt_o), (u + 1) % UNITS);
    endtask

    task automatic wait_cnt(input int v);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            #1;
            if (int'(poll_cnt_o) == v) break;
        end
    endtask

    initial begin
        #1000000;
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        #1;
        // R1
        check(poll_cnt_o == '0 && !busy_o && req_o == '0, "R1 reset state", int'(poll_cnt_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(poll_cnt_o == '0 && !busy_o && req_o == '0, "R1 first cycle", int'(poll_cnt_o), 0);

        // R3: free-running step with wrap
        prev = int'(poll_cnt_o);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1;
            check(int'(poll_cnt_o) == (prev + 1) % UNITS, "R3 idle step", int'(poll_cnt_o), (prev + 1) % UNITS);
            prev = int'(poll_cnt_o);
        end

        // R7: done on an idle bus has no effect
        @(negedge clk);
        done_i = '1;
        #1;
        prev = int'(poll_cnt_o);
        @(negedge clk);
        done_i = '0;
        #1;
        check(!busy_o && int'(poll_cnt_o) == (prev + 1) % UNITS, "R7 idle done ignored", int'(poll_cnt_o), (prev + 1) % UNITS);

        // R2/R4/R5/R7: one unit waiting for its number
        wait_cnt(1);
        expect_grant(5);
        @(negedge clk);
        want_i[5] = 1'b1;
        for (int k = 0; k < 16; k++) begin
            #1;
            if (int'(poll_cnt_o) == 5) begin
                check(req_o == 8'h20, "R4 polled request", int'(req_o), 32);
                break;
            end
            check(req_o == '0, "R2 unpolled silent", int'(req_o), 0);
            @(negedge clk);
        end
        @(negedge clk);
        expect_grant(2);
        want_i[2] = 1'b1;
        done_i[3] = 1'b1;
        #1;
        check(busy_o, "R4 busy after request", int'(busy_o), 1);
        check(int'(poll_cnt_o) == 5, "R5 frozen", int'(poll_cnt_o), 5);
        check(req_o == '0, "R8 no request while busy", int'(req_o), 0);
        @(negedge clk);
        done_i[3] = 1'b0;
        #1;
        check(busy_o, "R7 other done ignored", int'(busy_o), 1);
        @(negedge clk);
        done_i[5] = 1'b1;
        want_i[5] = 1'b0;
        #1;
        check(busy_o, "R7 busy until edge", int'(busy_o), 1);
        @(negedge clk);
        done_i[5] = 1'b0;
        #1;
        check(!busy_o && int'(poll_cnt_o) == 5, "R5 parked after fall", int'(poll_cnt_o), 5);
        @(negedge clk);
        #1;
        check(int'(poll_cnt_o) == 6, "R6 next after owner", int'(poll_cnt_o), 6);

        // unit 2 was waiting; serve it
        serve(2, 2);
        want_i[2] = 1'b0;

        // R6: two units keep wanting; rotation 4,1,4,1
        wait_cnt(2);
        @(negedge clk);
        want_i[1] = 1'b1;
        want_i[4] = 1'b1;
        expect_grant(4);
        expect_grant(1);
        expect_grant(4);
        expect_grant(1);
        serve(4, 1);
        serve(1, 3);
        serve(4, 0);
        serve(1, 2);
        @(negedge clk);
        want_i = '0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all grants seen", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule